// File: doc/BRIEF.md
# Nonvolatile Byte Store Access Controller

This block sits between a simple CPU register bus and an internal byte-wide nonvolatile store of 320 locations. The store is modelled as a register array. Software places a 9-bit location in two address registers, exchanges bytes through a data register, and starts each transfer by setting a strobe bit in a control register. While a transfer completes, the block holds the CPU with a stall output. A read holds the CPU longer than a write.

Writes are guarded by a two-step procedure. Software first sets an arming bit, which opens a short window, and then sets the write strobe inside that window. Once a write is accepted, a busy flag models the programming time. Strobes that arrive during that time are dropped. A location of 320 or above is never stored to, and reading one yields 0xFF.

Top module: `nvm_access_ctrl`

## Requirements
- R1: Register offsets on `bus_sel` are 0 for the address low byte, 1 for the address high byte, 2 for data and 3 for control. The high byte keeps only its bit 0, which is address bit 8, and its bits 7..1 always read as zero.
- R2: Every location from 0 to 319 can be written and later read back with the same byte.
- R3: An accepted read holds `cpu_stall` high for exactly 4 cycles, starting in the cycle after the accepting edge.
- R4: An accepted write holds `cpu_stall` high for exactly 2 cycles, starting in the cycle after the accepting edge.
- R5: A write stores the data register at the current address. A read loads the data register with the byte at the current address.
- R6: After reset the data register and the control register read 0x00, and `cpu_stall` and `nvm_busy` are low.
- R7: Control bit 2 is the arming bit. Setting it opens a window of 4 cycles. A write strobe (control bit 1) is accepted only if the arming bit was already set before that bus write, so setting both bits together does not write. The arming bit clears itself when the window ends or when a write is accepted.
- R8: Read and write strobes are ignored while `nvm_busy` or `cpu_stall` is high. An ignored strobe leaves the data register, the array and the stall output unchanged.
- R9: After an accepted write, `nvm_busy` is high for exactly 8 cycles. Control bit 3 reflects `nvm_busy`.
- R10: For an address of 320 or above, a read loads 0xFF and a write leaves the array unchanged. Address 320 does not alias to location 64.
- R11: The read strobe (control bit 0) and the write strobe (control bit 1) read back as 1 while their transfer is stalling, and clear themselves when the stall ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 2 | Register offset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read enable; read data is zero when low |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| cpu_stall | output | 1 | Holds the CPU after a transfer |
| nvm_busy | output | 1 | Write programming in progress |

## Verification
The arming window can expire in the same cycle that a write strobe arrives. The bench arms the block and waits two idle cycles, so that the strobe is sampled on the window's last cycle and must produce a two-cycle stall. It then repeats the sequence with one more idle cycle, where the stall must be absent and the stored byte must stay unchanged. A second collision is a read strobe that arrives while the busy timer from a previous write is still running. It is judged by reading back the control register, whose busy bit must be set and whose read bit must be clear, and the data register, which must be unchanged.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  // register offsets on the bus
  localparam logic [1:0] OFS_ALO = 2'd0;
  localparam logic [1:0] OFS_AHI = 2'd1;
  localparam logic [1:0] OFS_DAT = 2'd2;
  localparam logic [1:0] OFS_CTL = 2'd3;

  // control register bit positions
  localparam int CB_RD   = 0;
  localparam int CB_WR   = 1;
  localparam int CB_ARM  = 2;
  localparam int CB_BUSY = 3;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/nvm_arm_window.sv
module nvm_arm_window #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic arm_set,
  input  logic arm_kill,
  output logic armed
);
  localparam int CW = $clog2(WIN + 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (arm_kill)
      cnt_n = '0;
    else if (arm_set)
      cnt_n = CW'(WIN);
    else if (cnt_q != '0)
      cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)
      cnt_q <= '0;
    else
      cnt_q <= cnt_n;
  end

  assign armed = (cnt_q != '0);

  AST_ARM_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(armed) |-> $past(arm_set)); // R7
endmodule

// File: rtl/nvm_stall_timer.sv
module nvm_stall_timer
  import nvm_pkg::*;
#(
  parameter int RD_LEN = 4,
  parameter int WR_LEN = 2
) (
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      start,
  input  acc_kind_e start_kind,
  output logic      stall,
  output logic      rd_act,
  output logic      wr_act
);
  localparam int MAXL = (RD_LEN > WR_LEN) ? RD_LEN : WR_LEN;
  localparam int CW   = $clog2(MAXL + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  acc_kind_e     kind_q, kind_n;

  always_comb begin
    cnt_n  = cnt_q;
    kind_n = kind_q;
    if (start) begin
      kind_n = start_kind;
      cnt_n  = (start_kind == ACC_RD) ? CW'(RD_LEN) : CW'(WR_LEN);
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CW'(1))
        kind_n = ACC_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      kind_q <= ACC_NONE;
    end else begin
      cnt_q  <= cnt_n;
      kind_q <= kind_n;
    end
  end

  assign stall  = (cnt_q != '0);
  assign rd_act = stall && (kind_q == ACC_RD);
  assign wr_act = stall && (kind_q == ACC_WR);

  AST_STALL_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_ni)
    start |=> stall); // R3
  AST_NO_START_IN_STALL: assert property (@(posedge clk) disable iff (!rst_ni)
    start |-> !stall); // R8
  AST_ACT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({rd_act, wr_act})); // R11
endmodule

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer #(
  parameter int CYC = 8
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (start)
      cnt_n = CW'(CYC);
    else if (cnt_q != '0)
      cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)
      cnt_q <= '0;
    else
      cnt_q <= cnt_n;
  end

  assign busy = (cnt_q != '0);

  AST_BUSY_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_ni)
    start |=> busy); // R9
endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
  parameter int DEPTH = 320,
  parameter int AW    = 9,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          addr_ok
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];

  assign addr_ok = (addr <= LAST);

  always_ff @(posedge clk) begin
    if (we && addr_ok)
      mem[addr] <= wdata;
  end

  assign rdata = addr_ok ? mem[addr] : {DW{1'b1}};
endmodule

// File: rtl/nvm_access_ctrl.sv
module nvm_access_ctrl
  import nvm_pkg::*;
#(
  parameter int DEPTH    = 320,
  parameter int AW       = 9,
  parameter int RD_STALL = 4,
  parameter int WR_STALL = 2,
  parameter int ARM_WIN  = 4,
  parameter int BUSY_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_sel,
  input  logic       bus_we,
  input  logic       bus_re,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       cpu_stall,
  output logic       nvm_busy
);
  localparam int DW   = 8;
  localparam int HI_W = AW - DW;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // register decode
  logic hit_alo, hit_ahi, hit_dat, hit_ctl;
  assign hit_alo = bus_we && (bus_sel == OFS_ALO);
  assign hit_ahi = bus_we && (bus_sel == OFS_AHI);
  assign hit_dat = bus_we && (bus_sel == OFS_DAT);
  assign hit_ctl = bus_we && (bus_sel == OFS_CTL);

  // address registers carry no reset; software loads them first
  logic [DW-1:0]   addr_lo_q;
  logic [HI_W-1:0] addr_hi_q;
  logic [AW-1:0]   addr;

  always_ff @(posedge clk) begin
    if (hit_alo)
      addr_lo_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (hit_ahi)
      addr_hi_q <= bus_wdata[HI_W-1:0];
  end

  assign addr = {addr_hi_q, addr_lo_q};

  // transfer start logic
  logic armed, rd_act, wr_act, idle;
  logic rd_req, wr_req, rd_start, wr_start, arm_set;
  acc_kind_e start_kind;

  assign idle       = !cpu_stall && !nvm_busy;
  assign rd_req     = hit_ctl && bus_wdata[CB_RD];
  assign wr_req     = hit_ctl && bus_wdata[CB_WR];
  assign arm_set    = hit_ctl && bus_wdata[CB_ARM];
  assign wr_start   = wr_req && armed && idle;
  assign rd_start   = rd_req && idle && !wr_start;
  assign start_kind = wr_start ? ACC_WR : (rd_start ? ACC_RD : ACC_NONE);

  nvm_arm_window #(.WIN(ARM_WIN)) u_arm (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .arm_set  (arm_set),
    .arm_kill (wr_start),
    .armed    (armed)
  );

  nvm_stall_timer #(.RD_LEN(RD_STALL), .WR_LEN(WR_STALL)) u_stall (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .start      (rd_start || wr_start),
    .start_kind (start_kind),
    .stall      (cpu_stall),
    .rd_act     (rd_act),
    .wr_act     (wr_act)
  );

  nvm_busy_timer #(.CYC(BUSY_CYC)) u_busy (
    .clk    (clk),
    .rst_ni (rst_ni),
    .start  (wr_start),
    .busy   (nvm_busy)
  );

  // data register and array
  logic [DW-1:0] data_q, data_n, arr_rdata;
  logic          addr_ok;

  nvm_cell_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_cells (
    .clk     (clk),
    .we      (wr_start),
    .addr    (addr),
    .wdata   (data_q),
    .rdata   (arr_rdata),
    .addr_ok (addr_ok)
  );

  always_comb begin
    data_n = data_q;
    if (rd_start)
      data_n = arr_rdata;
    else if (hit_dat)
      data_n = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)
      data_q <= '0;
    else
      data_q <= data_n;
  end

  // read-back mux
  logic [DW-1:0] ctl_view, hi_view;

  always_comb begin
    ctl_view          = '0;
    ctl_view[CB_RD]   = rd_act;
    ctl_view[CB_WR]   = wr_act;
    ctl_view[CB_ARM]  = armed;
    ctl_view[CB_BUSY] = nvm_busy;
    hi_view           = '0;
    hi_view[HI_W-1:0] = addr_hi_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      case (bus_sel)
        OFS_ALO: bus_rdata = addr_lo_q;
        OFS_AHI: bus_rdata = hi_view;
        OFS_DAT: bus_rdata = data_q;
        default: bus_rdata = ctl_view;
      endcase
    end
  end

  AST_BUSY_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(nvm_busy) |-> $past(armed)); // R7
  AST_BUSY_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_ni)
    nvm_busy |=> !$rose(cpu_stall)); // R8
  AST_OOR_READ_ONES: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_start && !addr_ok) |=> (data_q == {DW{1'b1}})); // R10
  AST_WRITE_STALL_SHORT: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(wr_act) |-> nvm_busy); // R4
endmodule

// File: tb/tb_nvm_access_ctrl.sv
`timescale 1ns/1ps
module tb_nvm_access_ctrl;
  logic       clk;
  logic       rst_n;
  logic [1:0] bus_sel;
  logic       bus_we;
  logic       bus_re;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       cpu_stall;
  logic       nvm_busy;

  int checks;
  int errors;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  nvm_access_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cpu_stall (cpu_stall),
    .nvm_busy  (nvm_busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per register read
  always @(negedge clk) begin
    if (rst_n && bus_re) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL scoreboard: actual=%0h expected=none", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual=%02h expected=%02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic bwr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_sel = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic brd(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_sel = a; bus_re = 1'b1;
    @(posedge clk); #1;
    bus_re = 1'b0;
  endtask

  task automatic meas_stall(output int n);
    n = 0;
    @(negedge clk);
    while (cpu_stall) begin n++; @(negedge clk); end
  endtask

  task automatic meas_busy(output int n);
    n = 0;
    @(negedge clk);
    while (nvm_busy) begin n++; @(negedge clk); end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (cpu_stall || nvm_busy) @(negedge clk);
  endtask

  task automatic set_addr(input int a);
    logic [8:0] v;
    v = a[8:0];
    bwr(2'd0, v[7:0]);
    bwr(2'd1, {7'b0, v[8]});
  endtask

  task automatic armed_write(input int a, input logic [7:0] d);
    set_addr(a);
    bwr(2'd2, d);
    bwr(2'd3, 8'h04);
    bwr(2'd3, 8'h02);
  endtask

  task automatic read_expect(input int a, input logic [7:0] e, input string tag);
    set_addr(a);
    bwr(2'd2, ~e);
    bwr(2'd3, 8'h01);
    wait_idle();
    brd(2'd2, e, tag);
  endtask

  initial begin
    #(4 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int ns, nb;
    checks = 0; errors = 0;
    rst_n = 1'b0; bus_sel = '0; bus_we = 1'b0; bus_re = 1'b0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R6 reset state
    brd(2'd2, 8'h00, "R6 data reset");
    brd(2'd3, 8'h00, "R6 ctrl reset");
    chk("R6 stall low", int'(cpu_stall), 0);
    chk("R6 busy low", int'(nvm_busy), 0);

    // R1 address register split
    bwr(2'd1, 8'hFF);
    brd(2'd1, 8'h01, "R1 high byte reserved bits");
    bwr(2'd0, 8'hA7);
    brd(2'd0, 8'hA7, "R1 low byte");

    // R4 / R9 / R7: write inside window while arm read back
    set_addr(3);
    bwr(2'd2, 8'h5A);
    bwr(2'd3, 8'h04);
    brd(2'd3, 8'h04, "R7 arm bit set");
    bwr(2'd3, 8'h02);
    fork
      meas_stall(ns);
      meas_busy(nb);
    join
    chk("R4 write stall length", ns, 2);
    chk("R9 busy length", nb, 8);
    wait_idle();
    brd(2'd3, 8'h00, "R7 arm cleared by accepted write");
    read_expect(3, 8'h5A, "R5 write then read");

    // R3 read stall and R11 strobe readback
    set_addr(3);
    bwr(2'd3, 8'h01);
    meas_stall(ns);
    chk("R3 read stall length", ns, 4);
    bwr(2'd3, 8'h01);
    brd(2'd3, 8'h01, "R11 read bit during stall");
    wait_idle();
    brd(2'd3, 8'h00, "R11 read bit cleared");
    armed_write(4, 8'h66);
    brd(2'd3, 8'h0A, "R11 write bit during stall");
    wait_idle();
    brd(2'd3, 8'h00, "R11 write bit cleared");

    // R2 array edges
    armed_write(319, 8'hA5);
    wait_idle();
    armed_write(0, 8'h3C);
    wait_idle();
    read_expect(319, 8'hA5, "R2 top location");
    read_expect(0, 8'h3C, "R2 bottom location");

    // R7 unarmed write ignored
    armed_write(10, 8'h11);
    wait_idle();
    bwr(2'd2, 8'h77);
    bwr(2'd3, 8'h02);
    meas_stall(ns);
    chk("R7 unarmed write no stall", ns, 0);
    read_expect(10, 8'h11, "R7 unarmed write no store");

    // R7 window boundary: last window cycle accepted, one later rejected
    set_addr(20);
    bwr(2'd2, 8'h21);
    bwr(2'd3, 8'h04);
    repeat (2) @(posedge clk);
    bwr(2'd3, 8'h02);
    meas_stall(ns);
    chk("R7 strobe on last window cycle", ns, 2);
    wait_idle();
    bwr(2'd2, 8'h22);
    bwr(2'd3, 8'h04);
    repeat (3) @(posedge clk);
    bwr(2'd3, 8'h02);
    meas_stall(ns);
    chk("R7 strobe after window", ns, 0);
    brd(2'd3, 8'h00, "R7 arm self-clear");
    bwr(2'd2, 8'h23);
    bwr(2'd3, 8'h06);
    meas_stall(ns);
    chk("R7 arm and strobe together", ns, 0);
    repeat (6) @(posedge clk);
    read_expect(20, 8'h21, "R7 rejected writes kept old byte");

    // R10 out-of-range
    armed_write(64, 8'h42);
    wait_idle();
    armed_write(320, 8'h99);
    wait_idle();
    set_addr(320);
    bwr(2'd3, 8'h01);
    wait_idle();
    brd(2'd2, 8'hFF, "R10 out-of-range read");
    read_expect(64, 8'h42, "R10 out-of-range write no alias");

    // R8 read strobe during busy ignored
    armed_write(30, 8'h55);
    meas_stall(ns);
    bwr(2'd2, 8'hC3);
    bwr(2'd3, 8'h01);
    brd(2'd3, 8'h08, "R8 read strobe while busy");
    wait_idle();
    brd(2'd2, 8'hC3, "R8 data kept while busy");

    @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule